// File: doc/BRIEF.md
# Dual-Channel Serial Host Register Front End

This block is the bus-facing register front end of a two-channel serial controller mapped into a processor's memory space. The bus sees four byte-wide locations, selected by two address bits. Each of the two channels has one control port and one data port. The serial shifters are not part of the block. Received characters arrive on a strobe-and-byte input per channel. Characters to transmit leave on a holding-register output per channel, and a take pulse reports that the transmitter has consumed the byte.

Each channel reaches sixteen logical write registers and sixteen logical read registers through its single control port. With the channel's index pointer at zero, a control read returns the status register and a control write loads the pointer from its low four bits. While the pointer is non-zero, the next control access reads or writes the indexed configuration register, and the pointer then returns to zero. Status bits are gathered by a read multiplexer; there is no uniform register file behind the port. The interrupt request stays high while either channel holds an unread character.

Top module: `serial_host_regs`

## Requirements
- R1: `busAddr[1]` selects the channel (1 = A, 0 = B) and `busAddr[0]` selects the port (1 = data, 0 = control); an access touches only the selected channel.
- R2: When a channel's pointer is 0, a control read returns status: bit 0 = receive available, bit 2 = transmit ready, all other bits 0. A control write loads the pointer from `busWrData[3:0]` (a value of 0 leaves it at 0).
- R3: When the pointer holds n (1..15), the next control write stores the byte in configuration register n, and the next control read returns that byte. Either access returns the pointer to 0.
- R4: Each channel keeps its own pointer; accesses to one channel never change the other channel's pointer or configuration registers.
- R5: A receive strobe latches the byte and sets receive available on the next cycle. A strobe while a character is already waiting overwrites the held byte.
- R6: A data-port read returns the held received byte and clears receive available on the next cycle, unless a receive strobe arrives in the same cycle.
- R7: A data-port write while transmit ready is high loads the transmit byte output and clears transmit ready on the next cycle. A data-port write while transmit ready is low is ignored.
- R8: A transmit take pulse while transmit ready is low sets transmit ready on the next cycle.
- R9: `irq` is high exactly when either channel has receive available set.
- R10: Synchronous reset clears both pointers, all configuration registers, receive available, and the held and transmit bytes, and sets transmit ready.
- R11: `busRdData` is 0 whenever no read is in progress (`busValid` low or `busWrite` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Location select (channel, port) |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte, combinational |
| rxStrobeA | input | 1 | Channel A received-character strobe |
| rxByteA | input | 8 | Channel A received character |
| rxStrobeB | input | 1 | Channel B received-character strobe |
| rxByteB | input | 8 | Channel B received character |
| txTakeA | input | 1 | Channel A transmitter consumed byte |
| txTakeB | input | 1 | Channel B transmitter consumed byte |
| txByteA | output | 8 | Channel A byte to transmit |
| txByteB | output | 8 | Channel B byte to transmit |
| irq | output | 1 | Receive interrupt request |

## Verification
Read data is combinational, so a read result is due in the same cycle as the access and reflects state as of the previous edge. Flag changes, pointer changes, `irq` and the transmit byte all appear one clock after the stimulus edge. The bench drives inputs on the falling edge and compares every output against its reference model 2 ns later, before the next rising edge. The reference model is updated only at that rising edge, so each comparison covers exactly one edge's worth of effects.

// File: rtl/serial_host_pkg.sv
package serial_host_pkg;
  localparam int IDX_W = 4;
  localparam int NUM_REG = 1 << IDX_W;

  typedef struct packed {
    logic             ctrlWr;
    logic             dataRd;
    logic             dataWr;
    logic             pickData;
    logic [IDX_W-1:0] regIdx;
  } chanStrobeT;
endpackage

// File: rtl/serial_host_ctrl.sv
module serial_host_ctrl
  import serial_host_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [IDX_W-1:0]       ptrData,
  output chanStrobeT [NUM_CH-1:0] strb
);
  logic [CH_W-1:0] selCh;
  assign selCh = busAddr[ADDR_W-1:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [IDX_W-1:0] ptr;
    logic hit, ctrlHit, dataHit;

    assign hit     = busValid && (selCh == CH_W'(c));
    assign ctrlHit = hit && !busAddr[0];
    assign dataHit = hit && busAddr[0];

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr <= '0;
      end else if (ctrlHit) begin
        if (ptr == '0) begin
          if (busWrite) ptr <= ptrData;
        end else begin
          ptr <= '0;
        end
      end
    end

    always_comb begin
      strb[c].ctrlWr   = ctrlHit && busWrite;
      strb[c].dataRd   = dataHit && !busWrite;
      strb[c].dataWr   = dataHit && busWrite;
      strb[c].pickData = busAddr[0];
      strb[c].regIdx   = ptr;
    end
  end
endmodule

// File: rtl/serial_host_chan.sv
module serial_host_chan
  import serial_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  chanStrobeT        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txTake,
  output logic [DATA_W-1:0] rdByte,
  output logic [DATA_W-1:0] txByte,
  output logic              rxAvail,
  output logic              txReady
);
  localparam int RX_BIT = 0;
  localparam int TX_BIT = 2;

  logic [DATA_W-1:0] cfgReg [NUM_REG];
  logic [DATA_W-1:0] rxHold;
  logic [DATA_W-1:0] statusByte;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_cfg
    if (r == 0) begin : g_none
      assign cfgReg[r] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) cfgReg[r] <= '0;
        else if (strb.ctrlWr && strb.regIdx == IDX_W'(r)) cfgReg[r] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxHold  <= '0;
      rxAvail <= 1'b0;
    end else if (rxStrobe) begin
      rxHold  <= rxByte;
      rxAvail <= 1'b1;
    end else if (strb.dataRd) begin
      rxAvail <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txByte  <= '0;
      txReady <= 1'b1;
    end else if (txReady) begin
      if (strb.dataWr) begin
        txByte  <= wrData;
        txReady <= 1'b0;
      end
    end else if (txTake) begin
      txReady <= 1'b1;
    end
  end

  always_comb begin
    statusByte         = '0;
    statusByte[RX_BIT] = rxAvail;
    statusByte[TX_BIT] = txReady;
    if (strb.pickData)          rdByte = rxHold;
    else if (strb.regIdx == '0) rdByte = statusByte;
    else                        rdByte = cfgReg[strb.regIdx];
  end
endmodule

// File: rtl/serial_host_regs.sv
module serial_host_regs
  import serial_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxStrobeA,
  input  logic [DATA_W-1:0] rxByteA,
  input  logic              rxStrobeB,
  input  logic [DATA_W-1:0] rxByteB,
  input  logic              txTakeA,
  input  logic              txTakeB,
  output logic [DATA_W-1:0] txByteA,
  output logic [DATA_W-1:0] txByteB,
  output logic              irq
);
  localparam int NUM_CH = 2;

  chanStrobeT [NUM_CH-1:0] strb;
  logic [NUM_CH-1:0]       rxStrobeV, txTakeV, rxAvail, txReady;
  logic [DATA_W-1:0]       rxByteV [NUM_CH];
  logic [DATA_W-1:0]       txByteV [NUM_CH];
  logic [DATA_W-1:0]       chRd    [NUM_CH];

  assign rxStrobeV  = {rxStrobeA, rxStrobeB};
  assign txTakeV    = {txTakeA, txTakeB};
  assign rxByteV[0] = rxByteB;
  assign rxByteV[1] = rxByteA;

  serial_host_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .ptrData(busWrData[IDX_W-1:0]), .strb(strb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    serial_host_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst(rst), .strb(strb[c]), .wrData(busWrData),
      .rxStrobe(rxStrobeV[c]), .rxByte(rxByteV[c]), .txTake(txTakeV[c]),
      .rdByte(chRd[c]), .txByte(txByteV[c]),
      .rxAvail(rxAvail[c]), .txReady(txReady[c])
    );
  end

  assign busRdData = (busValid && !busWrite) ? chRd[busAddr[1]] : '0;
  assign txByteA   = txByteV[1];
  assign txByteB   = txByteV[0];
  assign irq       = |rxAvail;
endmodule

// File: rtl/serial_host_regs_chk.sv
module serial_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       busValid,
  input logic       busWrite,
  input logic [1:0] busAddr,
  input logic       rxStrobeA,
  input logic       txTakeA,
  input logic [7:0] txByteA,
  input logic       irq,
  input logic [1:0] rxAvail,
  input logic [1:0] txReady
);
  logic dataWrA, dataRdA;
  assign dataWrA = busValid && busWrite && busAddr == 2'b11;
  assign dataRdA = busValid && !busWrite && busAddr == 2'b11;

  // R5
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    rxStrobeA |=> rxAvail[1]);
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rxStrobeA |=> irq);
  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dataRdA && !rxStrobeA) |=> !rxAvail[1]);
  // R7
  tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (dataWrA && txReady[1]) |=> !txReady[1]);
  // R7
  tx_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (dataWrA && !txReady[1]) |=> $stable(txByteA));
  // R8
  tx_take_chk: assert property (@(posedge clk) disable iff (rst)
    (txTakeA && !txReady[1]) |=> txReady[1]);
  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (txReady == 2'b11 && rxAvail == 2'b00 && !irq));
endmodule

bind serial_host_regs serial_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .rxStrobeA(rxStrobeA), .txTakeA(txTakeA),
  .txByteA(txByteA), .irq(irq), .rxAvail(rxAvail), .txReady(txReady)
);

// File: tb/serial_host_regs_bench.sv
`timescale 1ns/1ps
module serial_host_regs_bench;
  logic clk = 0, rst = 1;
  logic busValid = 0, busWrite = 0;
  logic [1:0] busAddr = 0;
  logic [7:0] busWrData = 0, busRdData;
  logic rxStrobeA = 0, rxStrobeB = 0, txTakeA = 0, txTakeB = 0;
  logic [7:0] rxByteA = 0, rxByteB = 0, txByteA, txByteB;
  logic irq;

  int checks = 0, errors = 0;
  bit  done = 0;

  // reference model state, index 1 = A, 0 = B
  int       mPtr [2];
  bit       mRxAv [2], mTxRdy [2];
  logic [7:0] mRx [2], mTx [2];
  logic [7:0] mCfg [2][16];

  serial_host_regs u_serial_host_regs (.*);

  always #4 clk = ~clk;

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mPtr[c] = 0; mRxAv[c] = 0; mTxRdy[c] = 1; mRx[c] = 0; mTx[c] = 0;
      for (int r = 0; r < 16; r++) mCfg[c][r] = 0;
    end
  endtask

  function automatic logic [7:0] expRead(output string tag);
    int c;
    tag = "R11";
    if (!busValid || busWrite) return 8'h00;
    c = busAddr[1];
    if (busAddr[0]) begin tag = "R6 R1"; return mRx[c]; end
    if (mPtr[c] == 0) begin
      tag = "R2 R1";
      return {5'b0, mTxRdy[c], 1'b0, mRxAv[c]};
    end
    tag = "R3 R4";
    return mCfg[c][mPtr[c]];
  endfunction

  task automatic modelStep();
    bit strobe [2];
    bit take [2];
    logic [7:0] rb [2];
    strobe[1] = rxStrobeA; strobe[0] = rxStrobeB;
    take[1] = txTakeA; take[0] = txTakeB;
    rb[1] = rxByteA; rb[0] = rxByteB;
    if (rst) begin modelReset(); return; end
    for (int c = 0; c < 2; c++) begin
      bit hit;
      hit = busValid && busAddr[1] == c[0];
      if (hit && !busAddr[0]) begin
        if (mPtr[c] == 0) begin
          if (busWrite) mPtr[c] = busWrData[3:0];
        end else begin
          if (busWrite) mCfg[c][mPtr[c]] = busWrData;
          mPtr[c] = 0;
        end
      end
      if (hit && busAddr[0] && !busWrite) mRxAv[c] = 0;
      if (strobe[c]) begin mRxAv[c] = 1; mRx[c] = rb[c]; end
      if (mTxRdy[c]) begin
        if (hit && busAddr[0] && busWrite) begin mTx[c] = busWrData; mTxRdy[c] = 0; end
      end else if (take[c]) mTxRdy[c] = 1;
    end
  endtask

  task automatic tick();
    string tag;
    logic [7:0] e;
    #2;
    if (!rst) begin
      e = expRead(tag);
      check(tag, busRdData, e);
      check("R9", {7'b0, irq}, {7'b0, mRxAv[0] | mRxAv[1]});
      check("R7 R8 A", txByteA, mTx[1]);
      check("R7 R8 B", txByteB, mTx[0]);
    end
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle();
    busValid = 0; busWrite = 0;
    rxStrobeA = 0; rxStrobeB = 0; txTakeA = 0; txTakeB = 0;
  endtask

  task automatic acc(bit wr, logic [1:0] a, logic [7:0] d);
    busValid = 1; busWrite = wr; busAddr = a; busWrData = d;
    tick();
    idle();
  endtask

  initial begin
    modelReset();
    repeat (2) @(posedge clk);
    modelStep();
    @(negedge clk);
    rst = 0;
    // R10: reset state seen through status reads
    tick();
    acc(0, 2'b10, 0);
    acc(0, 2'b00, 0);
    // R5 R9: receive on A, status, data read clears
    rxStrobeA = 1; rxByteA = 8'h5A; tick(); idle();
    acc(0, 2'b10, 0);
    acc(0, 2'b11, 0);
    acc(0, 2'b10, 0);
    // R3: pointer write, config write, readback
    acc(1, 2'b10, 8'h03);
    acc(1, 2'b10, 8'hC3);
    acc(1, 2'b10, 8'h03);
    acc(0, 2'b10, 0);
    acc(0, 2'b10, 0);
    // R2: pointer value with zero low bits stays 0
    acc(1, 2'b10, 8'h10);
    acc(0, 2'b10, 0);
    // R4: pointer on B untouched by A access
    acc(1, 2'b00, 8'h07);
    acc(0, 2'b10, 0);
    acc(1, 2'b00, 8'h99);
    acc(1, 2'b00, 8'h07);
    acc(0, 2'b00, 0);
    acc(1, 2'b10, 8'h07);
    acc(0, 2'b10, 0);
    // R7 R8: transmit on B
    acc(1, 2'b01, 8'h11);
    acc(0, 2'b00, 0);
    acc(1, 2'b01, 8'h22);
    txTakeB = 1; tick(); idle();
    acc(1, 2'b01, 8'h33);
    // R5 R6: overwrite and simultaneous strobe + read
    rxStrobeB = 1; rxByteB = 8'hA1; tick(); idle();
    rxStrobeB = 1; rxByteB = 8'hB2; tick(); idle();
    rxStrobeB = 1; rxByteB = 8'hC3; busValid = 1; busWrite = 0; busAddr = 2'b01; tick(); idle();
    acc(0, 2'b00, 0);
    acc(0, 2'b01, 0);
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      busValid = $urandom_range(0, 1); busWrite = $urandom_range(0, 1);
      busAddr = 2'($urandom); busWrData = 8'($urandom);
      rxStrobeA = ($urandom_range(0, 7) == 0); rxByteA = 8'($urandom);
      rxStrobeB = ($urandom_range(0, 7) == 0); rxByteB = 8'($urandom);
      txTakeA = $urandom_range(0, 1); txTakeB = $urandom_range(0, 1);
      tick();
      if (i == 1000) begin
        // R10: mid-run reset
        idle(); rst = 1; tick(); rst = 0; tick();
      end
    end
    idle(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule